// File: doc/BRIEF.md
# Packed Sub-word Accumulator Unit

This unit performs packed integer arithmetic on two 64-bit operands that hold either four signed 16-bit elements or eight signed 8-bit elements. An ALU operation (lane-wise add or lane-wise multiply) is sent to one of two places. It can go back to the packed register file as a 64-bit result that wraps to the element width. It can also be widened and added slot by slot into one of four 192-bit accumulators. The accumulators hold every product and sum at full width, so a multiply-accumulate loop never needs to unpack or promote its data.

To bring a value out of an accumulator, a readout operation is used. A per-slot readout scales, rounds and clips each slot and packs the slots back into a 64-bit register word. A horizontal readout first adds every slot together and then scales, rounds and clips the single total. A clear operation zeroes one accumulator. Every operation is issued in a single cycle. Back-to-back accumulations into the same accumulator chain correctly.

Top module: `pacc_unit`

## Requirements
- R1: After reset, `res_valid` is 0 and all four accumulators hold zero, so any readout of any accumulator returns 0.
- R2: Opcode 000 (lane add) and opcode 001 (lane multiply) produce a 64-bit result one cycle after issue, with `res_valid` high. Each lane holds the low element-width bits of the lane sum or product. Lane i occupies bits [16i+15:16i] when `elem_mode`=0 and bits [8i+7:8i] when `elem_mode`=1.
- R3: Opcode bit 1 selects where an ALU result goes. Opcodes 010 (add into accumulator) and 011 (multiply into accumulator) update the accumulator chosen by `acc_sel`, and no result is produced in the next cycle.
- R4: With `elem_mode`=0, an accumulator holds four 48-bit slots, with slot i at bits [48i+47:48i] fed by lane i. The full signed sum or product is sign-extended to the slot width and then added.
- R5: With `elem_mode`=1, an accumulator holds eight 24-bit slots, with slot i at bits [24i+23:24i] fed by byte lane i. The widening is the same as in R4.
- R6: Each operation touches only the accumulator selected by `acc_sel`. The other three accumulators keep their values.
- R7: An accumulate issued in the cycle right after another accumulate to the same accumulator adds onto the updated sum.
- R8: Accumulator slots wrap modulo 2^slot-width. No saturation happens while accumulating.
- R9: Opcode 100 zeroes the selected accumulator in one cycle. An accumulate issued in the very next cycle starts from zero.
- R10: Opcode 101 rounds and shifts each slot (R12), clips it to the signed element range and packs it into lane i of the result.
- R11: Opcode 110 adds all slots of the selected accumulator and rounds and shifts the total (R12). It then clips the total to the signed element range and returns it sign-extended to 64 bits.
- R12: For a readout shift amount s>0, the value becomes (v + 2^(s-1)) >>> s, using an arithmetic shift. For s=0, the value passes through unchanged.
- R13: Opcode 111 is reserved. It produces no result and changes no accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 3 | Operation code (see R2, R3, R9 to R13) |
| acc_sel | input | 2 | Accumulator index |
| elem_mode | input | 1 | 0: 16-bit elements, 1: 8-bit elements |
| shift_amt | input | 5 | Readout arithmetic right-shift amount |
| src_a | input | 64 | Packed operand A |
| src_b | input | 64 | Packed operand B |
| res_valid | output | 1 | Result valid, one cycle after issue |
| res_data | output | 64 | Packed or reduced result |

## Verification
The bench chains two multiply-accumulates back to back. A unit that read a stale accumulator would show only one product at readout. It accumulates 512 byte products until a 24-bit slot passes its top. A unit that saturated while accumulating would then read out +127 where the wrapped value gives -128. It reads negative slots with a one-bit shift, where truncation instead of rounding gives -2 for -1. It also clears an accumulator and reuses it in the next cycle, and checks that the accumulators it did not select, and a reserved opcode, change nothing. Horizontal sums that overflow in the negative direction must clip to the most negative element and be sign-extended across the word.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    localparam int DATA_W  = 64;
    localparam int ACC_W   = 192;
    localparam int NUM_ACC = 4;
    localparam int SH_W    = 5;

    typedef enum logic [2:0] {
        OP_ADD     = 3'b000,
        OP_MUL     = 3'b001,
        OP_ADD_ACC = 3'b010,
        OP_MUL_ACC = 3'b011,
        OP_CLR     = 3'b100,
        OP_RD_PACK = 3'b101,
        OP_RD_SUM  = 3'b110,
        OP_RSVD    = 3'b111
    } op_e;
endpackage

// File: rtl/pacc_lane_alu.sv
module pacc_lane_alu #(
    parameter int DW = pacc_pkg::DATA_W,
    parameter int EW = 16,
    parameter int SW = 48
) (
    input  logic [DW-1:0]         a,
    input  logic [DW-1:0]         b,
    input  logic                  is_mul,
    output logic [DW-1:0]         wb,
    output logic [(DW/EW)*SW-1:0] wide
);
    localparam int NL = DW / EW;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [EW-1:0]   ea, eb;
        logic [2*EW-1:0] xa, xb, prod;
        logic [EW:0]     sum;
        assign ea   = a[i*EW +: EW];
        assign eb   = b[i*EW +: EW];
        assign xa   = {{EW{ea[EW-1]}}, ea};
        assign xb   = {{EW{eb[EW-1]}}, eb};
        assign prod = xa * xb;
        assign sum  = {ea[EW-1], ea} + {eb[EW-1], eb};
        assign wb[i*EW +: EW]   = is_mul ? prod[EW-1:0] : sum[EW-1:0];
        assign wide[i*SW +: SW] = is_mul ? {{(SW-2*EW){prod[2*EW-1]}}, prod}
                                         : {{(SW-EW-1){sum[EW]}}, sum};
    end
endmodule

// File: rtl/pacc_acc_bank.sv
module pacc_acc_bank #(
    parameter int NACC = pacc_pkg::NUM_ACC,
    parameter int AW   = pacc_pkg::ACC_W,
    parameter int SELW = $clog2(NACC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            add_en,
    input  logic            clr_en,
    input  logic [SELW-1:0] sel,
    input  logic            mode8,
    input  logic [AW-1:0]   wide16,
    input  logic [AW-1:0]   wide8,
    output logic [AW-1:0]   rd_word
);
    localparam int SW16 = AW / 4;
    localparam int SW8  = AW / 8;

    logic [AW-1:0] acc_q [NACC];
    logic [AW-1:0] cur, nxt16, nxt8, nxt;

    assign cur     = acc_q[sel];
    assign rd_word = cur;

    for (genvar i = 0; i < 4; i++) begin : g_s16
        assign nxt16[i*SW16 +: SW16] = cur[i*SW16 +: SW16] + wide16[i*SW16 +: SW16];
    end
    for (genvar j = 0; j < 8; j++) begin : g_s8
        assign nxt8[j*SW8 +: SW8] = cur[j*SW8 +: SW8] + wide8[j*SW8 +: SW8];
    end
    assign nxt = mode8 ? nxt8 : nxt16;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NACC; k++) acc_q[k] <= '0;
        end else if (clr_en) begin
            acc_q[sel] <= '0;
        end else if (add_en) begin
            acc_q[sel] <= nxt;
        end
    end

    // R9: a clear leaves the selected accumulator at zero
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> acc_q[$past(sel)] == '0);

    for (genvar k = 0; k < NACC; k++) begin : g_hold
        // R6: unselected accumulators do not move
        p_hold_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (add_en || clr_en) && sel != SELW'(k) |=> $stable(acc_q[k]));
    end
endmodule

// File: rtl/pacc_readout.sv
module pacc_readout #(
    parameter int AW  = pacc_pkg::ACC_W,
    parameter int DW  = pacc_pkg::DATA_W,
    parameter int SHW = pacc_pkg::SH_W
) (
    input  logic [AW-1:0]  acc_word,
    input  logic           mode8,
    input  logic           do_sum,
    input  logic [SHW-1:0] shamt,
    output logic [DW-1:0]  out_word
);
    localparam int SW16 = AW / 4;
    localparam int SW8  = AW / 8;
    localparam int XW   = SW16 + 8;
    localparam logic signed [XW-1:0] MAX16 = XW'(32767);
    localparam logic signed [XW-1:0] MIN16 = XW'(-32768);
    localparam logic signed [XW-1:0] MAX8  = XW'(127);
    localparam logic signed [XW-1:0] MIN8  = XW'(-128);

    function automatic logic signed [XW-1:0] scale(logic signed [XW-1:0] v,
                                                   logic [SHW-1:0] s);
        logic signed [XW-1:0] half, t;
        if (s == '0) return v;
        half = XW'(1) << (s - SHW'(1));
        t    = v + half;
        return t >>> s;
    endfunction

    function automatic logic [15:0] sat16(logic signed [XW-1:0] v);
        if (v > MAX16) return 16'h7FFF;
        if (v < MIN16) return 16'h8000;
        return v[15:0];
    endfunction

    function automatic logic [7:0] sat8(logic signed [XW-1:0] v);
        if (v > MAX8) return 8'h7F;
        if (v < MIN8) return 8'h80;
        return v[7:0];
    endfunction

    logic [DW-1:0] pk16, pk8;
    logic signed [XW-1:0] tot16, tot8, tot_sc;
    logic signed [XW-1:0] x16 [4];
    logic signed [XW-1:0] x8  [8];

    for (genvar i = 0; i < 4; i++) begin : g_r16
        assign x16[i] = {{(XW-SW16){acc_word[i*SW16+SW16-1]}}, acc_word[i*SW16 +: SW16]};
        assign pk16[i*16 +: 16] = sat16(scale(x16[i], shamt));
    end
    for (genvar j = 0; j < 8; j++) begin : g_r8
        assign x8[j] = {{(XW-SW8){acc_word[j*SW8+SW8-1]}}, acc_word[j*SW8 +: SW8]};
        assign pk8[j*8 +: 8] = sat8(scale(x8[j], shamt));
    end

    always_comb begin
        tot16 = '0;
        tot8  = '0;
        for (int i = 0; i < 4; i++) tot16 = tot16 + x16[i];
        for (int j = 0; j < 8; j++) tot8 = tot8 + x8[j];
        tot_sc = scale(mode8 ? tot8 : tot16, shamt);
    end

    logic [15:0] s16;
    logic [7:0]  s8;
    assign s16 = sat16(tot_sc);
    assign s8  = sat8(tot_sc);

    always_comb begin
        if (do_sum)     out_word = mode8 ? {{(DW-8){s8[7]}}, s8} : {{(DW-16){s16[15]}}, s16};
        else if (mode8) out_word = pk8;
        else            out_word = pk16;
    end
endmodule

// File: rtl/pacc_unit.sv
module pacc_unit
    import pacc_pkg::*;
#(
    parameter int DW   = pacc_pkg::DATA_W,
    parameter int AW   = pacc_pkg::ACC_W,
    parameter int NACC = pacc_pkg::NUM_ACC,
    parameter int SHW  = pacc_pkg::SH_W,
    parameter int SELW = $clog2(NACC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [2:0]      op_code,
    input  logic [SELW-1:0] acc_sel,
    input  logic            elem_mode,
    input  logic [SHW-1:0]  shift_amt,
    input  logic [DW-1:0]   src_a,
    input  logic [DW-1:0]   src_b,
    output logic            res_valid,
    output logic [DW-1:0]   res_data
);
    op_e op;
    logic wb_en, add_en, clr_en, rd_en, do_sum;
    logic [DW-1:0] wb16, wb8, rd_out;
    logic [AW-1:0] wide16, wide8, acc_word;

    assign op = op_e'(op_code);

    always_comb begin
        wb_en = 1'b0; add_en = 1'b0; clr_en = 1'b0; rd_en = 1'b0; do_sum = 1'b0;
        unique case (op)
            OP_ADD, OP_MUL:         wb_en  = op_valid;
            OP_ADD_ACC, OP_MUL_ACC: add_en = op_valid;
            OP_CLR:                 clr_en = op_valid;
            OP_RD_PACK:             rd_en  = op_valid;
            OP_RD_SUM:    begin     rd_en  = op_valid; do_sum = 1'b1; end
            OP_RSVD:                ;
        endcase
    end

    pacc_lane_alu #(.DW(DW), .EW(16), .SW(AW/4)) u_alu16 (
        .a(src_a), .b(src_b), .is_mul(op_code[0]), .wb(wb16), .wide(wide16));
    pacc_lane_alu #(.DW(DW), .EW(8), .SW(AW/8)) u_alu8 (
        .a(src_a), .b(src_b), .is_mul(op_code[0]), .wb(wb8), .wide(wide8));

    pacc_acc_bank #(.NACC(NACC), .AW(AW), .SELW(SELW)) u_bank (
        .clk(clk), .rst_n(rst_n), .add_en(add_en), .clr_en(clr_en), .sel(acc_sel),
        .mode8(elem_mode), .wide16(wide16), .wide8(wide8), .rd_word(acc_word));

    pacc_readout #(.AW(AW), .DW(DW), .SHW(SHW)) u_rd (
        .acc_word(acc_word), .mode8(elem_mode), .do_sum(do_sum),
        .shamt(shift_amt), .out_word(rd_out));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= wb_en | rd_en;
            if (wb_en)      res_data <= elem_mode ? wb8 : wb16;
            else if (rd_en) res_data <= rd_out;
        end
    end

    // R2: write-back operations answer in the next cycle
    p_wb_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code[2:1] == 2'b00 |=> res_valid);
    // R3: accumulating operations return nothing
    p_acc_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code[2:1] == 2'b01 |=> !res_valid);
    // R11: 16-bit horizontal readout is sign-extended across the word
    p_sum_sext_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 3'b110 && !elem_mode |=> res_data[DW-1:16] == {(DW-16){res_data[15]}});
    // R13: reserved code yields no result
    p_rsvd_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && op_code == 3'b111 |=> !res_valid);
endmodule

// File: tb/pacc_unit_tb.sv
module pacc_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [1:0]  acc_sel;
    logic        elem_mode;
    logic [4:0]  shift_amt;
    logic [63:0] src_a, src_b;
    logic        res_valid;
    logic [63:0] res_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pacc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_sel(acc_sel), .elem_mode(elem_mode), .shift_amt(shift_amt),
        .src_a(src_a), .src_b(src_b), .res_valid(res_valid), .res_data(res_data));

    function automatic longint rsat(longint v, int sh, int bits);
        longint t = v;
        longint mx = (64'sd1 <<< (bits-1)) - 1;
        longint mn = -(64'sd1 <<< (bits-1));
        if (sh > 0) t = (t + (64'sd1 <<< (sh-1))) >>> sh;
        if (t > mx) t = mx;
        if (t < mn) t = mn;
        return t;
    endfunction

    function automatic logic [15:0] l16(longint v, int sh);
        return 16'(rsat(v, sh, 16));
    endfunction

    function automatic logic [7:0] l8(longint v, int sh);
        return 8'(rsat(v, sh, 8));
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // drive at a falling edge; returns at the next falling edge with op_valid low
    task automatic issue(logic [2:0] c, logic [1:0] s, logic m8, logic [4:0] sh,
                         logic [63:0] a, logic [63:0] b);
        op_valid = 1'b1; op_code = c; acc_sel = s; elem_mode = m8;
        shift_amt = sh; src_a = a; src_b = b;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic rd(logic [2:0] c, logic [1:0] s, logic m8, logic [4:0] sh);
        issue(c, s, m8, sh, 64'h0, 64'h0);
    endtask

    task automatic t_reset;
        chk("R1 res_valid", {63'b0, res_valid}, 64'h0);
        for (int k = 0; k < 4; k++) begin
            rd(3'b101, 2'(k), 1'b0, 5'd0);
            chk("R1 acc zero", res_data, 64'h0);
        end
    endtask

    task automatic t_wb;
        issue(3'b000, 2'd0, 1'b0, 5'd0, 64'h0064_FFFD_0001_7FFF, 64'hFF9C_FFFC_0002_0001);
        chk("R2 add16 valid", {63'b0, res_valid}, 64'h1);
        chk("R2 add16", res_data, 64'h0000_FFF9_0003_8000);
        issue(3'b001, 2'd0, 1'b0, 5'd0, 64'h0000_7FFF_0003_0100, 64'h0000_0002_FFFE_0100);
        chk("R2 mul16", res_data, 64'h0000_FFFE_FFFA_0000);
        issue(3'b000, 2'd0, 1'b1, 5'd0, 64'h0000_0000_0000_FF7F, 64'h0000_0000_0000_0101);
        chk("R2 add8", res_data, 64'h0000_0000_0000_0080);
    endtask

    task automatic t_mac16;
        longint s0 = 2 * 32767 * 32767;
        longint s1 = -2 * 32767;
        longint s2 = 12;
        issue(3'b011, 2'd1, 1'b0, 5'd0, 64'h0000_0002_FFFF_7FFF, 64'h0000_0003_7FFF_7FFF);
        chk("R3 no result on accumulate", {63'b0, res_valid}, 64'h0);
        issue(3'b011, 2'd1, 1'b0, 5'd0, 64'h0000_0002_FFFF_7FFF, 64'h0000_0003_7FFF_7FFF);
        rd(3'b101, 2'd1, 1'b0, 5'd0);
        chk("R4 R7 R10 pack16", res_data, {l16(0, 0), l16(s2, 0), l16(s1, 0), l16(s0, 0)});
        rd(3'b101, 2'd1, 1'b0, 5'd16);
        chk("R4 pack16 shift16", res_data, {l16(0, 16), l16(s2, 16), l16(s1, 16), l16(s0, 16)});
        rd(3'b110, 2'd1, 1'b0, 5'd16);
        chk("R11 sum16", res_data, 64'(rsat(s0 + s1 + s2, 16, 16)));
        rd(3'b101, 2'd0, 1'b0, 5'd0);
        chk("R6 acc0 untouched", res_data, 64'h0);
    endtask

    task automatic t_round;
        issue(3'b011, 2'd2, 1'b0, 5'd0, 64'h0000_0005_FFFD_0003, 64'h0000_0001_0001_0001);
        rd(3'b101, 2'd2, 1'b0, 5'd0);
        chk("R12 shift0", res_data, 64'h0000_0005_FFFD_0003);
        rd(3'b101, 2'd2, 1'b0, 5'd1);
        chk("R12 round shift1", res_data, {l16(0, 1), l16(5, 1), l16(-3, 1), l16(3, 1)});
    endtask

    task automatic t_lay8;
        issue(3'b011, 2'd3, 1'b1, 5'd0, 64'h0807_0605_0403_0201, 64'h0202_0202_0202_0202);
        rd(3'b101, 2'd3, 1'b1, 5'd0);
        chk("R5 pack8", res_data, 64'h100E_0C0A_0806_0402);
        rd(3'b110, 2'd3, 1'b1, 5'd2);
        chk("R5 R11 sum8", res_data, 64'(rsat(72, 2, 8)));
        issue(3'b100, 2'd3, 1'b0, 5'd0, 64'h0, 64'h0);
        issue(3'b010, 2'd3, 1'b1, 5'd0, 64'h0000_0000_0000_007F, 64'h0000_0000_0000_007F);
        rd(3'b101, 2'd3, 1'b1, 5'd1);
        chk("R5 wide add8", res_data, {56'h0, l8(254, 1)});
    endtask

    task automatic t_wrap8;
        longint w = 512 * 16384;
        if (w >= (64'sd1 <<< 23)) w = w - (64'sd1 <<< 24);
        issue(3'b100, 2'd0, 1'b1, 5'd0, 64'h0, 64'h0);
        for (int n = 0; n < 512; n++)
            issue(3'b011, 2'd0, 1'b1, 5'd0, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080);
        rd(3'b101, 2'd0, 1'b1, 5'd16);
        chk("R8 slot wraps", res_data, {8{l8(w, 16)}});
    endtask

    task automatic t_clear;
        issue(3'b100, 2'd1, 1'b0, 5'd0, 64'h0, 64'h0);
        issue(3'b011, 2'd1, 1'b0, 5'd0, 64'h0000_0000_0000_0002, 64'h0000_0000_0000_0003);
        rd(3'b101, 2'd1, 1'b0, 5'd0);
        chk("R9 clear then accumulate", res_data, 64'h0000_0000_0000_0006);
        rd(3'b101, 2'd2, 1'b0, 5'd0);
        chk("R6 acc2 kept", res_data, 64'h0000_0005_FFFD_0003);
    endtask

    task automatic t_reserved;
        issue(3'b111, 2'd1, 1'b0, 5'd0, 64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222);
        chk("R13 no result", {63'b0, res_valid}, 64'h0);
        rd(3'b101, 2'd1, 1'b0, 5'd0);
        chk("R13 acc unchanged", res_data, 64'h0000_0000_0000_0006);
    endtask

    task automatic t_neg_sum;
        longint p = -32768 * 32767;
        issue(3'b100, 2'd2, 1'b0, 5'd0, 64'h0, 64'h0);
        issue(3'b011, 2'd2, 1'b0, 5'd0, 64'h8000_8000_8000_8000, 64'h7FFF_7FFF_7FFF_7FFF);
        rd(3'b110, 2'd2, 1'b0, 5'd0);
        chk("R11 negative clip", res_data, 64'(rsat(4 * p, 0, 16)));
        rd(3'b110, 2'd2, 1'b0, 5'd31);
        chk("R11 R12 shift31", res_data, 64'(rsat(4 * p, 31, 16)));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = 3'b0; acc_sel = 2'd0;
        elem_mode = 1'b0; shift_amt = 5'd0; src_a = '0; src_b = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_wb;
        t_mac16;
        t_round;
        t_lay8;
        t_wrap8;
        t_clear;
        t_reserved;
        t_neg_sum;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule